// File: doc/BRIEF.md
# Smart-Card Character Transmitter with Automatic Retry

This block sends one asynchronous character at a time on the shared, open-drain I/O line of a half-duplex smart-card link that uses the character-level T=0 protocol. Each character is a low start bit, eight data bits sent least significant bit first, and an even-parity bit. Two released guard periods follow. The receiving card may signal a parity error by pulling the line low during the guard period. The block samples the line at a fixed point in that guard time. On an error it resends the same character without software help, up to a limit set by a 3-bit iteration field.

The host writes a byte while the ready flag is high, and the flag stays low until the character is finished. A character is finished when it is accepted or when its retries are used up. When the repeat count reaches the programmed limit, the block sets a sticky iteration flag, which stays set until the host pulses the clear command. The block does not generate the elementary time unit (ETU). It receives a one-cycle `etu_tick` strobe per ETU from outside. The pad is modelled as a drive-low enable output plus a sampled line input.

Top module: `sc_t0_tx`

## Requirements
- R1: After reset `tx_ready` is 1, `io_drive_low` is 0 and `iter_flag` is 0.
- R2: Each attempt drives a frame of ten ETU slots starting at an `etu_tick`. Slot 0 is low (start). Slots 1 to 8 carry data bits 0 to 7, where `io_drive_low` = 1 means a 0 bit. Slot 9 carries a parity bit that makes the number of ones in data plus parity even. The line is then released.
- R3: The error sample is taken on the `etu_tick` that ends the first released ETU after the parity bit. A low `io_in` there is a NACK. A low level that starts later in the second guard ETU is not a NACK.
- R4: With `max_iter` = 0 a character is sent exactly once, whatever the card answers.
- R5: With `max_iter` = N > 0 a character that keeps receiving NACKs is sent N+1 times in total, so never more than 8 times.
- R6: A repeat that is acknowledged ends the character. The repeat counter restarts from zero for the next character.
- R7: `iter_flag` becomes 1 when the repeat count of a character reaches a nonzero `max_iter`. It then stays 1 until it is cleared.
- R8: A one-cycle pulse on `iter_clr` clears `iter_flag` by the next cycle.
- R9: After a NACK, a repeat begins only after `io_in` has returned high and at least two further ETUs have passed.
- R10: After the last allowed attempt the block finishes the character even if that attempt also received a NACK. It sends no further frame of it.
- R11: `tx_load` while `tx_ready` is 1 captures `tx_data` and drops `tx_ready` on the next cycle. `tx_ready` rises again once the character is finished.
- R12: `tx_load` while `tx_ready` is 0 is ignored. The character in flight and the frames sent are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| etu_tick | input | 1 | One-cycle strobe marking each ETU boundary |
| tx_data | input | 8 | Character to send |
| tx_load | input | 1 | Write strobe for `tx_data` |
| tx_ready | output | 1 | High when a new character may be written |
| max_iter | input | 3 | Repeat limit, captured when a character is accepted |
| iter_clr | input | 1 | Pulse to clear the iteration flag |
| iter_flag | output | 1 | Sticky flag: the repeat limit was reached |
| io_in | input | 1 | Sampled level of the shared I/O line |
| io_drive_low | output | 1 | Open-drain enable: 1 pulls the line low |

## Verification
The assertions assume that `etu_tick` is a single-cycle strobe with many clocks between strobes. They also assume that the card answers a NACK only by pulling the line low from the middle of the first guard ETU and releasing it later. The bench produces a strobe every four clocks. Its card model decodes every frame and pulls the line low for two ETUs only on the attempts scripted for an error. It keeps `max_iter` constant while a character is in flight. One extra case pulls the line low only in the second guard ETU, after the sample point, to show that such a level is not taken as an error.

// File: rtl/t0tx_pkg.sv
// Shared definitions for the smart-card character transmitter.
// Assumes one character format: start, data, parity, released guard time.
package t0tx_pkg;
    localparam int DATA_W    = 8;
    localparam int ITER_W    = 3;
    localparam int GUARD_ETU = 2;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_ARM,
        SQ_BITS,
        SQ_GUARD1,
        SQ_GUARD2,
        SQ_HOLD,
        SQ_BACKOFF
    } seq_state_t;
endpackage

// File: rtl/t0tx_frame_seq.sv
// Frame sequencer: serialises one attempt (start, data LSB first, even
// parity), samples the line at the end of the first guard ETU, and on an
// error waits for line release plus GUARD_ETU ticks before reporting.
// Assumes etu_tick is a one-cycle strobe and data is stable while busy.
module t0tx_frame_seq
    import t0tx_pkg::*;
#(
    parameter int DW    = DATA_W,
    parameter int GUARD = GUARD_ETU
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          etu_tick,
    input  logic          start,
    input  logic [DW-1:0] data,
    input  logic          io_in,
    output logic          line_low,
    output logic          frame_done,
    output logic          frame_nack
);
    localparam int SLOT_N = DW + 2;
    localparam int SLOT_W = $clog2(SLOT_N);
    localparam int GC_W   = $clog2(GUARD + 1);

    seq_state_t        state;
    logic [SLOT_W-1:0] slot;
    logic [GC_W-1:0]   gcnt;
    logic [SLOT_N-1:0] fvec;

    // Frame image: slot 0 start, then data, then even parity.
    always_comb fvec = {^data, data, 1'b0};

    // Attempt state machine advanced on ETU strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= SQ_IDLE;
            slot       <= '0;
            gcnt       <= '0;
            line_low   <= 1'b0;
            frame_done <= 1'b0;
            frame_nack <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (start) state <= SQ_ARM;
                end
                SQ_ARM: begin
                    if (etu_tick) begin
                        state    <= SQ_BITS;
                        slot     <= '0;
                        line_low <= ~fvec[0];
                    end
                end
                SQ_BITS: begin
                    if (etu_tick) begin
                        if (slot == SLOT_W'(SLOT_N - 1)) begin
                            state    <= SQ_GUARD1;
                            line_low <= 1'b0;
                        end else begin
                            slot     <= slot + 1'b1;
                            line_low <= ~fvec[slot + 1'b1];
                        end
                    end
                end
                SQ_GUARD1: begin
                    if (etu_tick) state <= io_in ? SQ_GUARD2 : SQ_HOLD;
                end
                SQ_GUARD2: begin
                    if (etu_tick) begin
                        state      <= SQ_IDLE;
                        frame_done <= 1'b1;
                        frame_nack <= 1'b0;
                    end
                end
                SQ_HOLD: begin
                    if (etu_tick && io_in) begin
                        state <= SQ_BACKOFF;
                        gcnt  <= '0;
                    end
                end
                SQ_BACKOFF: begin
                    if (etu_tick) begin
                        if (gcnt == GC_W'(GUARD - 1)) begin
                            state      <= SQ_IDLE;
                            frame_done <= 1'b1;
                            frame_nack <= 1'b1;
                        end else begin
                            gcnt <= gcnt + 1'b1;
                        end
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    AST_GUARD_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state != SQ_BITS) |-> !line_low); // R2
    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (state == SQ_IDLE)); // R11
    AST_NACK_WAITS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_HOLD && !io_in) |=> (state == SQ_HOLD)); // R9
endmodule

// File: rtl/t0tx_retry_ctl.sv
// Retry controller: counts repeats of the current character against the
// limit captured at acceptance, requests a new attempt after a NACK while
// budget remains, and keeps the sticky iteration flag.
// Assumes frame_done is a one-cycle pulse per finished attempt.
module t0tx_retry_ctl
    import t0tx_pkg::*;
#(
    parameter int IW = ITER_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          char_go,
    input  logic [IW-1:0] max_iter,
    input  logic          frame_done,
    input  logic          frame_nack,
    input  logic          iter_clr,
    output logic          retry_go,
    output logic          char_done,
    output logic          iter_flag
);
    logic [IW-1:0] rep_cnt;
    logic [IW-1:0] max_q;
    logic          rep_step;
    logic          rep_last;

    // A repeat is granted only for a NACK with budget left.
    always_comb begin
        rep_step = frame_done && frame_nack && (rep_cnt < max_q);
        rep_last = rep_step && ((rep_cnt + 1'b1) == max_q);
    end

    // Repeat counter, captured limit and attempt/character pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rep_cnt   <= '0;
            max_q     <= '0;
            retry_go  <= 1'b0;
            char_done <= 1'b0;
        end else begin
            retry_go  <= 1'b0;
            char_done <= 1'b0;
            if (char_go) begin
                max_q   <= max_iter;
                rep_cnt <= '0;
            end
            if (rep_step) begin
                rep_cnt  <= rep_cnt + 1'b1;
                retry_go <= 1'b1;
            end else if (frame_done) begin
                rep_cnt   <= '0;
                char_done <= 1'b1;
            end
        end
    end

    // Sticky iteration flag; clear command wins over a same-cycle set.
    always_ff @(posedge clk) begin
        if (!rst_n)        iter_flag <= 1'b0;
        else if (iter_clr) iter_flag <= 1'b0;
        else if (rep_last) iter_flag <= 1'b1;
    end

    AST_REPEAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rep_cnt <= max_q); // R5
    AST_ZERO_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (max_q == '0) |-> !retry_go); // R4
    AST_ACK_ENDS_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !frame_nack) |=> (char_done && !retry_go)); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (iter_flag && !iter_clr) |=> iter_flag); // R7
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        iter_clr |=> !iter_flag); // R8
endmodule

// File: rtl/sc_t0_tx.sv
// Top: single-entry holding register with ready flag, wired to the frame
// sequencer and the retry controller. A character is accepted only while
// ready is high; ready returns when the character is finished.
// Assumes max_iter is held steady while a character is being accepted.
module sc_t0_tx
    import t0tx_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int IW = ITER_W,
    parameter int GUARD = GUARD_ETU
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          etu_tick,
    input  logic [DW-1:0] tx_data,
    input  logic          tx_load,
    output logic          tx_ready,
    input  logic [IW-1:0] max_iter,
    input  logic          iter_clr,
    output logic          iter_flag,
    input  logic          io_in,
    output logic          io_drive_low
);
    logic [DW-1:0] hold_q;
    logic          char_go;
    logic          retry_go;
    logic          char_done;
    logic          frame_done;
    logic          frame_nack;

    // Accept a write only while the holding register is free.
    always_comb char_go = tx_load && tx_ready;

    // Holding register and ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q   <= '0;
            tx_ready <= 1'b1;
        end else if (char_go) begin
            hold_q   <= tx_data;
            tx_ready <= 1'b0;
        end else if (char_done) begin
            tx_ready <= 1'b1;
        end
    end

    t0tx_frame_seq #(.DW(DW), .GUARD(GUARD)) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .etu_tick   (etu_tick),
        .start      (char_go | retry_go),
        .data       (hold_q),
        .io_in      (io_in),
        .line_low   (io_drive_low),
        .frame_done (frame_done),
        .frame_nack (frame_nack)
    );

    t0tx_retry_ctl #(.IW(IW)) i_retry (
        .clk        (clk),
        .rst_n      (rst_n),
        .char_go    (char_go),
        .max_iter   (max_iter),
        .frame_done (frame_done),
        .frame_nack (frame_nack),
        .iter_clr   (iter_clr),
        .retry_go   (retry_go),
        .char_done  (char_done),
        .iter_flag  (iter_flag)
    );

    AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        char_go |=> !tx_ready); // R11
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_ready && $past(!tx_ready)) |-> $stable(hold_q)); // R12
endmodule

// File: tb/test_sc_t0_tx.sv
module test_sc_t0_tx;
    localparam int TICK = 4;

    typedef struct {
        logic [7:0] data;
        int         nacks;
        int         allowed;
        bit         late;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       etu_tick = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_load = 1'b0;
    logic       tx_ready;
    logic [2:0] max_iter = '0;
    logic       iter_clr = 1'b0;
    logic       iter_flag;
    logic       io_in;
    logic       io_drive_low;
    logic       card_low = 1'b0;

    int   n_cmp = 0;
    int   n_bad = 0;
    int   cyc = 0;
    exp_t q[$];

    always #2 clk = ~clk;
    assign io_in = ~(io_drive_low | card_low);

    sc_t0_tx i_sc_t0_tx (
        .clk(clk), .rst_n(rst_n), .etu_tick(etu_tick),
        .tx_data(tx_data), .tx_load(tx_load), .tx_ready(tx_ready),
        .max_iter(max_iter), .iter_clr(iter_clr), .iter_flag(iter_flag),
        .io_in(io_in), .io_drive_low(io_drive_low)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Cycle counter.
    initial forever begin
        @(posedge clk);
        cyc++;
    end

    // ETU strobe: one cycle in every TICK.
    initial begin
        int tcnt;
        tcnt = 0;
        forever begin
            @(negedge clk);
            tcnt = (tcnt + 1) % TICK;
            etu_tick = (tcnt == 0);
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog (R11): actual hung expected finished");
        finish_run();
    end

    // Monitor / card model: decodes frames, pops the scoreboard.
    initial begin
        int   attempt;
        bit   pend_gap;
        int   rel_cyc;
        logic [7:0] got;
        logic par;
        bit   nack_now;
        exp_t it;
        attempt = 0;
        pend_gap = 0;
        rel_cyc = 0;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (io_drive_low) begin
                if (pend_gap) begin
                    chk("R9 gap after NACK >= 2 ETU", int'((cyc - rel_cyc) >= 2 * TICK), 1);
                    pend_gap = 0;
                end
                @(negedge clk);
                chk("R2 start bit low", io_drive_low, 1);
                got = '0;
                for (int i = 0; i < 8; i++) begin
                    repeat (TICK) @(negedge clk);
                    got[i] = ~io_drive_low;
                end
                repeat (TICK) @(negedge clk);
                par = ~io_drive_low;
                repeat (TICK) @(negedge clk);
                chk("R2 guard released", io_drive_low, 0);
                chk("R2 parity even", int'(par), int'(^got));
                if (q.size() == 0) begin
                    chk("R10 no extra frame", 1, 0);
                end else begin
                    it = q[0];
                    chk("R2 data bits", got, it.data);
                    nack_now = (attempt < it.nacks);
                    if (nack_now) begin
                        card_low = 1'b1;
                        repeat (2 * TICK) @(negedge clk);
                        card_low = 1'b0;
                        rel_cyc = cyc;
                    end else if (it.late) begin
                        repeat (TICK) @(negedge clk);
                        card_low = 1'b1;
                        repeat (TICK) @(negedge clk);
                        card_low = 1'b0;
                    end
                    attempt++;
                    if (!nack_now || attempt == it.allowed) begin
                        void'(q.pop_front());
                        attempt = 0;
                    end else begin
                        pend_gap = 1;
                    end
                end
            end
        end
    end

    // Driver: pushes the expected item, writes the character, waits for finish.
    task automatic send(input logic [7:0] d, input int mx, input int nk,
                        input bit late, input bit busy_poke);
        exp_t e;
        while (!tx_ready) @(negedge clk);
        e.data = d;
        e.nacks = nk;
        e.allowed = (mx == 0) ? 1 : mx + 1;
        e.late = late;
        q.push_back(e);
        max_iter = 3'(mx);
        tx_data = d;
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
        chk("R11 ready drops after load", tx_ready, 0);
        if (busy_poke) begin
            repeat (3) @(negedge clk);
            tx_data = ~d;
            tx_load = 1'b1;
            @(negedge clk);
            tx_load = 1'b0;
        end
        while (!tx_ready) @(negedge clk);
        repeat (4 * TICK) @(negedge clk);
        chk("R5 R10 attempt count matched", q.size(), 0);
        chk("R11 ready after finish", tx_ready, 1);
    endtask

    task automatic clear_flag();
        iter_clr = 1'b1;
        @(negedge clk);
        iter_clr = 1'b0;
        @(negedge clk);
        chk("R8 flag cleared", iter_flag, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", tx_ready, 1);
        chk("R1 line released after reset", io_drive_low, 0);
        chk("R1 flag clear after reset", iter_flag, 0);

        send(8'hA5, 0, 0, 0, 0);                 // plain character
        send(8'h3C, 0, 1, 0, 0);                 // R4: no repeat at limit 0
        chk("R4 no flag at limit 0", iter_flag, 0);
        send(8'h81, 3, 2, 0, 0);                 // R6: ack on second repeat
        chk("R6 no flag when acked early", iter_flag, 0);
        send(8'h5A, 3, 5, 0, 0);                 // R10: runs out of retries
        chk("R7 flag set at limit", iter_flag, 1);
        repeat (20) @(negedge clk);
        chk("R7 flag sticky", iter_flag, 1);
        clear_flag();
        send(8'hFF, 7, 9, 0, 0);                 // R5: eight attempts max
        chk("R7 flag set at limit 7", iter_flag, 1);
        clear_flag();
        send(8'h00, 2, 1, 0, 0);                 // R6: counter restarted
        chk("R6 fresh budget no flag", iter_flag, 0);
        send(8'hC3, 3, 0, 1, 0);                 // R3: late low is not NACK
        chk("R3 late low not an error", iter_flag, 0);
        send(8'h6E, 1, 0, 0, 1);                 // R12: busy write ignored
        chk("R12 no flag from busy write", iter_flag, 0);
        finish_run();
    end
endmodule